// File: doc/BRIEF.md
# Dual-Issue Pairing Check Unit

This unit sits in the decode stage of an in-order pipeline that can issue two instructions per cycle. Every cycle fetch presents a 64-bit packet holding two 32-bit instructions. The unit decides whether zero, one or two instructions leave decode. It reports the count and the issued instruction words, and it tells fetch whether the packet has been taken.

Two instructions pair only when one is a floating-point operation and the other uses the integer/memory pipe. A floating-point load counts as an integer/memory instruction, so it can pair with an FP operation. The younger instruction of a pair never issues without the older one.

Hazard checks compare the destination of the older instruction with the sources of the younger one. They also compare both instructions against a load that issued in the previous cycle. When only the older instruction of a packet issues, the right-hand instruction is kept inside the unit. In the next cycle it becomes the oldest instruction and can pair with the left instruction of the next packet.

Top module: `dip_pair_issue`

## Requirements
- R1: While reset is asserted, and in any cycle after reset with `pkt_valid` low and no instruction held, `issue_cnt` is 0, both issued words are 0 and `fetch_stall` is 0.
- R2: Packet layout: the left (older) instruction is in bits [63:32] and the right instruction is in bits [31:0]. Instruction fields are class [31:30], rd [29:25], rs1 [24:20] and rs2 [19:15]. The class codes are:
  - 00, integer ALU: reads integer rs1 and rs2, writes integer rd.
  - 01, integer load: reads integer rs1, writes integer rd.
  - 10, FP load: reads integer rs1, writes FP rd.
  - 11, FP operation: reads FP rs1 and rs2, writes FP rd.
- R3: Two instructions issue together only if exactly one of them has class 11. In particular, an FP load (class 10) may pair with an FP operation.
- R4: Issue is in order. The younger instruction of the window issues only if the older one issues in the same cycle, and `issue0_instr` always carries the older instruction.
- R5: The younger instruction is blocked if it reads the register that the older one writes, in the same register file. Register index 0 never creates a dependence.
- R6: When a load (class 01 or 10) with rd not 0 issues in cycle t, no instruction that reads that register may issue in cycle t+1. If the oldest instruction reads it, `issue_cnt` is 0 in that cycle. The restriction ends after cycle t+1.
- R7: If only the older instruction of a fresh packet issues, the right instruction is held. In the next cycle the held instruction is the oldest, and the left instruction of the presented packet is the younger one. Both may issue together under R3 to R6, whichever of the two is the FP operation.
- R8: `fetch_stall` is 1 when `pkt_valid` is 1 and the packet is not taken. A packet is taken once every instruction in it has issued, or has issued except for the right instruction, which then moves into the hold. While stalled, fetch presents the same packet again.
- R9: `issue_cnt` equals the number of instructions issued in the cycle. An issued slot carries the instruction word, and a slot that does not issue reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A fetch packet is presented |
| pkt_data | input | 64 | Left instruction in [63:32], right instruction in [31:0] |
| issue_cnt | output | 2 | Instructions issued this cycle (0, 1 or 2) |
| issue0_instr | output | 32 | Older issued instruction, 0 if none |
| issue1_instr | output | 32 | Younger issued instruction, 0 if none |
| fetch_stall | output | 1 | Packet not taken; re-present it next cycle |

## Verification
A corrupted hold register shows up at the ports in the very next cycle. `issue0_instr` then carries a word that fetch never presented in that position, and the stall decision for the packet presented alongside it flips. A load-shadow entry that is wrongly kept or lost changes `issue_cnt` only in the one cycle after the load. For that reason the bench places dependent instructions directly behind loads, both in the same packet and in the next one. Because the outputs are compared with a stream-level model in every cycle, any divergence is reported in the cycle where it first appears.

// File: rtl/dip_pkg.sv
package dip_pkg;
    localparam int INSTR_W = 32;
    localparam int PKT_W   = 2 * INSTR_W;
    localparam int REG_W   = 5;
    localparam int CLS_W   = 2;
    localparam int RD_HI   = INSTR_W - CLS_W - 1;
    localparam int RS1_HI  = RD_HI - REG_W;
    localparam int RS2_HI  = RS1_HI - REG_W;
    localparam int WIN     = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU = 2'b00,
        CLS_LD  = 2'b01,
        CLS_FLD = 2'b10,
        CLS_FOP = 2'b11
    } cls_e;

    typedef struct packed {
        logic             vld;
        logic             is_fop;
        logic             is_load;
        logic             dst_vld;
        logic             dst_fp;
        logic [REG_W-1:0] dst;
        logic             src_fp;
        logic             s1_vld;
        logic [REG_W-1:0] s1;
        logic             s2_vld;
        logic [REG_W-1:0] s2;
    } dec_t;

    typedef struct packed {
        logic             vld;
        logic             fp;
        logic [REG_W-1:0] idx;
    } wr_t;

    typedef struct packed {
        logic               hold_vld;
        logic [INSTR_W-1:0] hold_instr;
        wr_t                shadow;
    } state_t;

    function automatic dec_t f_dec(logic v, logic [INSTR_W-1:0] w);
        dec_t d;
        cls_e c;
        c         = cls_e'(w[INSTR_W-1 -: CLS_W]);
        d.vld     = v;
        d.is_fop  = v && (c == CLS_FOP);
        d.is_load = v && ((c == CLS_LD) || (c == CLS_FLD));
        d.dst     = w[RD_HI -: REG_W];
        d.s1      = w[RS1_HI -: REG_W];
        d.s2      = w[RS2_HI -: REG_W];
        d.dst_vld = v && (d.dst != '0);
        d.dst_fp  = (c == CLS_FLD) || (c == CLS_FOP);
        d.src_fp  = (c == CLS_FOP);
        d.s1_vld  = v && (d.s1 != '0);
        d.s2_vld  = v && (d.s2 != '0) && ((c == CLS_ALU) || (c == CLS_FOP));
        return d;
    endfunction

    function automatic wr_t f_wr(dec_t d);
        wr_t r;
        r.vld = d.dst_vld;
        r.fp  = d.dst_fp;
        r.idx = d.dst;
        return r;
    endfunction

    function automatic logic f_reads(dec_t d, wr_t p);
        return p.vld && d.vld && (p.fp == d.src_fp) &&
               ((d.s1_vld && (d.s1 == p.idx)) || (d.s2_vld && (d.s2 == p.idx)));
    endfunction
endpackage

// File: rtl/dip_decode.sv
module dip_decode
    import dip_pkg::*;
(
    input  logic               vld,
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    always_comb begin
        dec = f_dec(vld, instr);
    end
endmodule

// File: rtl/dip_raw.sv
module dip_raw
    import dip_pkg::*;
(
    input  wr_t  prod,
    input  dec_t cons,
    output logic hit
);
    always_comb begin
        hit = f_reads(cons, prod);
    end
endmodule

// File: rtl/dip_pair_issue.sv
module dip_pair_issue
    import dip_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pkt_valid,
    input  logic [PKT_W-1:0]   pkt_data,
    output logic [1:0]         issue_cnt,
    output logic [INSTR_W-1:0] issue0_instr,
    output logic [INSTR_W-1:0] issue1_instr,
    output logic               fetch_stall
);
    state_t st_q, st_d;

    logic [INSTR_W-1:0] pkt_left, pkt_right;
    logic [INSTR_W-1:0] win_w [WIN];
    logic               win_v [WIN];
    dec_t               dec   [WIN];
    logic               sh_hit[WIN];
    logic               pair_hit;
    wr_t                old_wr;
    logic               old_ok, young_ok, mix, accept;

    assign pkt_left  = pkt_data[PKT_W-1 -: INSTR_W];
    assign pkt_right = pkt_data[INSTR_W-1:0];

    // Window: a held instruction is always the oldest.
    always_comb begin
        win_w[0] = st_q.hold_vld ? st_q.hold_instr : pkt_left;
        win_v[0] = st_q.hold_vld | pkt_valid;
        win_w[1] = st_q.hold_vld ? pkt_left : pkt_right;
        win_v[1] = pkt_valid;
    end

    generate
        for (genvar g = 0; g < WIN; g++) begin : g_pos
            dip_decode u_dec (
                .vld   (win_v[g]),
                .instr (win_w[g]),
                .dec   (dec[g])
            );
            dip_raw u_sh (
                .prod (st_q.shadow),
                .cons (dec[g]),
                .hit  (sh_hit[g])
            );
        end
    endgenerate

    assign old_wr = f_wr(dec[0]);

    dip_raw u_pair (
        .prod (old_wr),
        .cons (dec[1]),
        .hit  (pair_hit)
    );

    always_comb begin
        st_d     = st_q;
        old_ok   = dec[0].vld && !sh_hit[0];
        mix      = dec[0].is_fop != dec[1].is_fop;
        young_ok = old_ok && dec[1].vld && mix && !pair_hit && !sh_hit[1];
        accept   = st_q.hold_vld ? young_ok : old_ok;

        if (st_q.hold_vld) begin
            if (young_ok) begin
                st_d.hold_vld   = 1'b1;
                st_d.hold_instr = pkt_right;
            end else if (old_ok) begin
                st_d.hold_vld   = 1'b0;
                st_d.hold_instr = '0;
            end
        end else if (old_ok && !young_ok) begin
            st_d.hold_vld   = 1'b1;
            st_d.hold_instr = pkt_right;
        end

        st_d.shadow = '0;
        if (young_ok && dec[1].is_load) begin
            st_d.shadow = f_wr(dec[1]);
        end else if (old_ok && dec[0].is_load) begin
            st_d.shadow = old_wr;
        end

        issue_cnt    = young_ok ? 2'd2 : (old_ok ? 2'd1 : 2'd0);
        issue0_instr = old_ok   ? win_w[0] : '0;
        issue1_instr = young_ok ? win_w[1] : '0;
        fetch_stall  = pkt_valid && !accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Checker state: load write seen on the issue outputs last cycle.
    wr_t  ld_wr_q;
    dec_t out_dec0, out_dec1;
    assign out_dec0 = f_dec(issue_cnt != 2'd0, issue0_instr);
    assign out_dec1 = f_dec(issue_cnt == 2'd2, issue1_instr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_wr_q <= '0;
        end else if (out_dec1.is_load) begin
            ld_wr_q <= f_wr(out_dec1);
        end else if (out_dec0.is_load) begin
            ld_wr_q <= f_wr(out_dec0);
        end else begin
            ld_wr_q <= '0;
        end
    end

    AST_PAIR_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> (out_dec0.is_fop != out_dec1.is_fop)); // R3

    AST_YOUNG_NEEDS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue1_instr != '0) |-> (issue_cnt == 2'd2)); // R4

    AST_NO_PAIR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> !f_reads(out_dec1, f_wr(out_dec0))); // R5

    AST_LOAD_SHADOW_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt != 2'd0) |-> !f_reads(out_dec0, ld_wr_q)); // R6

    AST_LOAD_SHADOW_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> !f_reads(out_dec1, ld_wr_q)); // R6

    AST_SINGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.hold_vld && issue_cnt == 2'd1) |=> st_q.hold_vld); // R7

    AST_STALL_NEEDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> pkt_valid); // R8
endmodule

// File: tb/sim_dip_pair_issue.sv
`timescale 1ns/1ps
module sim_dip_pair_issue;
    localparam int NPKT = 1024;
    localparam int NINS = 2 * NPKT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt_data = '0;
    logic [1:0]  issue_cnt;
    logic [31:0] issue0_instr, issue1_instr;
    logic        fetch_stall;

    int errors = 0;
    int checks = 0;
    int hit_r3 = 0, hit_r5 = 0, hit_r6 = 0, hit_r7 = 0, hit_two = 0;

    logic [31:0] prog [NINS];

    always #10 clk = ~clk;

    dip_pair_issue u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .issue_cnt(issue_cnt), .issue0_instr(issue0_instr),
        .issue1_instr(issue1_instr), .fetch_stall(fetch_stall)
    );

    function automatic logic [31:0] mk(int c, int rd, int r1, int r2);
        return {c[1:0], rd[4:0], r1[4:0], r2[4:0], 15'h0};
    endfunction

    function automatic int cls(logic [31:0] w);
        return int'(w[31:30]);
    endfunction

    // Register read per R2 / R5: fp selects the file, index 0 never matches.
    function automatic bit reads(logic [31:0] w, bit fp, int idx);
        int c = cls(w);
        bit sfp = (c == 3);
        if (idx == 0 || sfp != fp) return 0;
        if (int'(w[24:20]) == idx) return 1;
        if ((c == 0 || c == 3) && int'(w[19:15]) == idx) return 1;
        return 0;
    endfunction

    function automatic bit dst_fp(logic [31:0] w);
        return cls(w) >= 2;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int mi = 0, mp = 0;
        bit sh_v = 0, sh_fp = 0;
        int sh_idx = 0;
        int k = 0;

        // Directed preamble, then random packets with small register indices.
        prog[k++] = mk(2, 0, 1, 0);  prog[k++] = mk(3, 2, 0, 3);  // FP load f0 pairs with FP op reading f0
        prog[k++] = mk(1, 4, 1, 0);  prog[k++] = mk(3, 5, 6, 7);  // load r4 + FP op
        prog[k++] = mk(0, 6, 4, 2);  prog[k++] = mk(3, 8, 5, 1);  // reads r4 next cycle: shadow
        prog[k++] = mk(0, 7, 1, 2);  prog[k++] = mk(0, 8, 7, 1);  // two ALU: single, hold
        prog[k++] = mk(3, 1, 2, 3);  prog[k++] = mk(3, 4, 1, 2);  // held ALU + FP op, hold FP op
        prog[k++] = mk(0, 9, 1, 2);  prog[k++] = mk(2, 9, 1, 0);  // held FP older + ALU younger
        prog[k++] = mk(3, 10, 9, 1); prog[k++] = mk(3, 11, 2, 3); // FP load f9 then reader of f9
        prog[k++] = mk(1, 0, 2, 0);  prog[k++] = mk(0, 3, 0, 0);  // load to r0: no shadow
        while (k < NINS) prog[k++] = mk($urandom_range(3), $urandom_range(3),
                                        $urandom_range(3), $urandom_range(3));

        repeat (3) @(negedge clk);
        #5;
        check("R1", issue_cnt, 0, "cnt in reset");
        check("R1", fetch_stall, 0, "stall in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R1", issue_cnt, 0, "cnt idle after reset");
        check("R1", fetch_stall, 0, "stall idle after reset");
        check("R1", issue0_instr, 0, "slot0 idle after reset");

        while (mp < NPKT) begin
            int lim, ni;
            bit e0, e1, raw, shy, mixok, acc;
            int exp_cnt;
            logic [31:0] x0, x1;
            string tag;
            @(negedge clk);
            pkt_valid = (mi < 16) ? 1'b1 : ($urandom_range(7) != 0);
            pkt_data  = {prog[2*mp], prog[2*mp+1]};
            #5;
            lim = pkt_valid ? 2*mp + 1 : 2*mp - 1;
            e0 = (mi <= lim) && !(sh_v && reads(prog[mi], sh_fp, sh_idx));
            e1 = 0; raw = 0; shy = 0; mixok = 0;
            if (mi + 1 <= lim) begin
                mixok = (cls(prog[mi]) == 3) != (cls(prog[mi+1]) == 3);
                raw   = reads(prog[mi+1], dst_fp(prog[mi]), int'(prog[mi][29:25]));
                shy   = sh_v && reads(prog[mi+1], sh_fp, sh_idx);
                e1    = e0 && mixok && !raw && !shy;
            end
            exp_cnt = e0 + e1;
            x0 = e0 ? prog[mi] : 32'h0;
            x1 = e1 ? prog[mi+1] : 32'h0;
            ni = mi + exp_cnt;
            acc = pkt_valid && (ni >= 2*mp + 1);

            if ((mi <= lim && !e0) || (e0 && shy)) begin tag = "R6"; hit_r6++; end
            else if (e0 && mi + 1 <= lim && raw) begin tag = "R5"; hit_r5++; end
            else if (e0 && mi + 1 <= lim && !mixok) begin tag = "R3"; hit_r3++; end
            else if (mi % 2 == 1) begin tag = "R7"; hit_r7++; end
            else tag = "R4";
            if (mi % 2 == 1 && e1) hit_r7++;
            if (e1 && cls(prog[mi]) == 2) hit_r3++;
            if (e1) hit_two++;

            check(tag, issue_cnt, exp_cnt, "issue count");
            check("R9", issue0_instr, x0, "slot0 word");
            check("R9", issue1_instr, x1, "slot1 word");
            check("R8", fetch_stall, pkt_valid && !acc, "fetch stall");

            sh_v = 0;
            if (e1 && cls(prog[mi+1]) inside {1, 2}) begin
                sh_v = (prog[mi+1][29:25] != 0); sh_fp = dst_fp(prog[mi+1]); sh_idx = int'(prog[mi+1][29:25]);
            end else if (e0 && cls(prog[mi]) inside {1, 2}) begin
                sh_v = (prog[mi][29:25] != 0); sh_fp = dst_fp(prog[mi]); sh_idx = int'(prog[mi][29:25]);
            end
            mi = ni;
            if (acc) mp++;
        end

        @(negedge clk);
        pkt_valid = 1'b0;
        check("R3", hit_r3 > 0, 1, "class-blocked or FP-load pairing seen");
        check("R5", hit_r5 > 0, 1, "pair dependence seen");
        check("R6", hit_r6 > 0, 1, "load shadow seen");
        check("R7", hit_r7 > 0, 1, "held instruction seen");
        check("R4", hit_two > 0, 1, "dual issue seen");
        finish_run();
    end
endmodule